// File: doc/BRIEF.md
# Data Lane Burst Sequencer

This block runs the entry into and exit from high-speed transmission for one data lane of a link that switches between low-power signalling and high-speed serial signalling. When a burst is requested and the clock lane reports a running clock, the block leaves the stop state. It steps through a low-power request, a bridge (prepare) interval and a high-speed zero interval, and then sends a fixed sync byte. After the sync byte it serializes payload bytes taken from a valid/ready byte stream. The burst ends with a trail interval that holds the inverse of the last bit sent, followed by an exit interval in the stop state.

The block sends one bit per clock cycle, so one clock period is one bit period (`UI_PS` picoseconds). Every interval length is a cycle count set on a configuration input. The prepare, trail and exit counts are clamped to limits that the block derives at elaboration from fixed nanosecond figures plus bit-period terms. A byte carrying the last flag ends the burst. So does a missing byte at a load point, because a high-speed burst cannot pause.

Top module: `lane_burst_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `line_st` is 0 (stop), `hs_bit` is 0 and `s_ready` is 0.
- R2: The block leaves the stop state only at a clock edge where `start_req` and `clk_lane_rdy` are both high. From the next cycle, `line_st` shows code 1 (low-power request) for max(`cfg_lpx`,1) cycles.
- R3: Code 2 (bridge/prepare) follows the request. It is held for `cfg_prep` cycles, clamped to [ceil(40000/UI_PS)+4, floor(85000/UI_PS)+6], which is [9,16] at the default bit period.
- R4: After prepare, code 3 (high speed) is shown with `hs_bit`=0 for max(`cfg_zero`,1) cycles. The sync byte 8'hB8 then follows LSB first, one bit per cycle.
- R5: During trail, `line_st` is 3 and `hs_bit` is held at the inverse of the last bit sent before trail.
- R6: Trail lasts `cfg_trail` cycles, clamped to [max(8, ceil(60000/UI_PS)+4), floor(105000/UI_PS)+12], which is [12,25] at the default bit period.
- R7: After trail, `line_st` is 0 for max(`cfg_exit`, ceil(100000/UI_PS)) cycles (13 at the default) plus one idle cycle. Only after that can the next request appear.
- R8: `s_ready` is high for exactly one cycle: the cycle carrying the last sync bit, or the last bit of a byte without the last flag. When `s_valid` is also high, that byte is sent LSB first over the next 8 cycles.
- R9: After the 8th bit of a byte accepted with `s_last` high, trail starts at once and `s_ready` stays low.
- R10: If `s_valid` is low while `s_ready` is high, trail starts in the next cycle.
- R11: `hs_bit` is 0 whenever `line_st` is not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_lane_rdy | input | 1 | Clock lane reports the high-speed clock is running |
| start_req | input | 1 | Request to start a burst |
| cfg_lpx | input | CNT_W | Low-power request length in cycles |
| cfg_prep | input | CNT_W | Prepare length in cycles, clamped |
| cfg_zero | input | CNT_W | High-speed zero length in cycles |
| cfg_trail | input | CNT_W | Trail length in cycles, clamped |
| cfg_exit | input | CNT_W | Exit stop length in cycles, floored |
| s_data | input | BYTE_W | Payload byte |
| s_valid | input | 1 | Payload byte valid |
| s_last | input | 1 | Payload byte is the last of the burst |
| s_ready | output | 1 | Payload byte taken at this edge if valid |
| line_st | output | 2 | Line state: 0 stop, 1 request, 2 bridge, 3 high speed |
| hs_bit | output | 1 | Serial bit while high speed, else 0 |

## Verification
All outputs come straight from registers. The first request cycle therefore shows one cycle after the edge that sees `start_req` and `clk_lane_rdy`, and each later interval starts in the cycle right after the previous one ends. `s_ready` is the one exception: it is a decode of the current state and is valid in the same cycle as the last bit of a byte. The bench samples at the falling edge. It walks the expected interval list one cycle at a time and compares line code, serial bit and ready in every cycle. Every interval length is therefore checked to the exact cycle, and the lane must show the next request exactly one cycle after the exit interval ends.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;

    typedef enum logic [1:0] {
        LINE_STOP   = 2'd0,
        LINE_REQ    = 2'd1,
        LINE_BRIDGE = 2'd2,
        LINE_HS     = 2'd3
    } line_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_PREP,
        ST_ZERO,
        ST_SYNC,
        ST_DATA,
        ST_TRAIL,
        ST_EXIT
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lane_seq_clamp.sv
module lane_seq_clamp #(
    parameter int W  = 8,
    parameter int LO = 1,
    parameter int HI = (1 << W) - 1
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] eff
);
    localparam logic [W-1:0] LO_V   = W'(LO);
    localparam logic [W-1:0] HI_V   = W'(HI);
    localparam bit           HAS_HI = (HI < ((1 << W) - 1));

    generate
        if (HAS_HI) begin : g_window
            always_comb begin
                if (raw < LO_V) begin
                    eff = LO_V;
                end else if (raw > HI_V) begin
                    eff = HI_V;
                end else begin
                    eff = raw;
                end
            end
        end else begin : g_floor
            always_comb begin
                eff = (raw < LO_V) ? LO_V : raw;
            end
        end
    endgenerate
endmodule

// File: rtl/lane_seq_shift.sv
module lane_seq_shift #(
    parameter int BYTE_W    = 8,
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift_en,
    output logic              cur_bit,
    output logic              last_bit
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic              last;
    } shift_t;

    shift_t cur_q, nxt_d;
    logic   head;
    logic [BYTE_W-1:0] moved;

    generate
        if (LSB_FIRST) begin : g_lsb
            assign head  = cur_q.sh[0];
            assign moved = cur_q.sh >> 1;
        end else begin : g_msb
            assign head  = cur_q.sh[BYTE_W-1];
            assign moved = cur_q.sh << 1;
        end
    endgenerate

    always_comb begin
        nxt_d = cur_q;
        if (shift_en) begin
            nxt_d.sh   = moved;
            nxt_d.last = head;
        end
        if (load) begin
            nxt_d.sh = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cur_bit  = head;
    assign last_bit = cur_q.last;
endmodule

// File: rtl/lane_burst_seq.sv
module lane_burst_seq
    import lane_seq_pkg::*;
#(
    parameter int                CNT_W     = 8,
    parameter int                BYTE_W    = 8,
    parameter int                UI_PS     = 8000,
    parameter logic [BYTE_W-1:0] SYNC_WORD = BYTE_W'(8'hB8),
    parameter bit                LSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_lane_rdy,
    input  logic              start_req,
    input  logic [CNT_W-1:0]  cfg_lpx,
    input  logic [CNT_W-1:0]  cfg_prep,
    input  logic [CNT_W-1:0]  cfg_zero,
    input  logic [CNT_W-1:0]  cfg_trail,
    input  logic [CNT_W-1:0]  cfg_exit,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic [1:0]        line_st,
    output logic              hs_bit
);
    localparam int PREP_LO  = ceil_div(40000, UI_PS) + 4;
    localparam int PREP_HI  = (85000 / UI_PS) + 6;
    localparam int TRAIL_LO = max_int(8, ceil_div(60000, UI_PS) + 4);
    localparam int TRAIL_HI = (105000 / UI_PS) + 12;
    localparam int EXIT_LO  = ceil_div(100000, UI_PS);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] BYTE_CT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             last;
    } seq_t;

    seq_t seq_q, seq_d;

    logic [CNT_W-1:0]  lpx_eff, prep_eff, zero_eff, trail_eff, exit_eff;
    logic              ld, shift_en, cur_bit, last_bit, tick;
    logic [BYTE_W-1:0] ld_val;

    lane_seq_clamp #(.W(CNT_W), .LO(1)) u_lpx (.raw(cfg_lpx), .eff(lpx_eff));
    lane_seq_clamp #(.W(CNT_W), .LO(PREP_LO), .HI(PREP_HI)) u_prep (.raw(cfg_prep), .eff(prep_eff));
    lane_seq_clamp #(.W(CNT_W), .LO(1)) u_zero (.raw(cfg_zero), .eff(zero_eff));
    lane_seq_clamp #(.W(CNT_W), .LO(TRAIL_LO), .HI(TRAIL_HI)) u_trail (.raw(cfg_trail), .eff(trail_eff));
    lane_seq_clamp #(.W(CNT_W), .LO(EXIT_LO)) u_exit (.raw(cfg_exit), .eff(exit_eff));

    lane_seq_shift #(.BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .shift_en (shift_en),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    assign tick = (seq_q.cnt == '0);

    always_comb begin
        seq_d    = seq_q;
        ld       = 1'b0;
        ld_val   = s_data;
        shift_en = 1'b0;
        s_ready  = 1'b0;
        if (!tick) begin
            seq_d.cnt = seq_q.cnt - ONE;
        end
        unique case (seq_q.state)
            ST_IDLE: begin
                seq_d.cnt = '0;
                if (start_req && clk_lane_rdy) begin
                    seq_d.state = ST_REQ;
                    seq_d.cnt   = lpx_eff - ONE;
                end
            end
            ST_REQ: begin
                if (tick) begin
                    seq_d.state = ST_PREP;
                    seq_d.cnt   = prep_eff - ONE;
                end
            end
            ST_PREP: begin
                if (tick) begin
                    seq_d.state = ST_ZERO;
                    seq_d.cnt   = zero_eff - ONE;
                end
            end
            ST_ZERO: begin
                if (tick) begin
                    seq_d.state = ST_SYNC;
                    seq_d.cnt   = BYTE_CT;
                    ld          = 1'b1;
                    ld_val      = SYNC_WORD;
                end
            end
            ST_SYNC, ST_DATA: begin
                shift_en = 1'b1;
                if (tick) begin
                    if (seq_q.state == ST_DATA && seq_q.last) begin
                        seq_d.state = ST_TRAIL;
                        seq_d.cnt   = trail_eff - ONE;
                    end else begin
                        s_ready = 1'b1;
                        if (s_valid) begin
                            seq_d.state = ST_DATA;
                            seq_d.cnt   = BYTE_CT;
                            seq_d.last  = s_last;
                            ld          = 1'b1;
                        end else begin
                            seq_d.state = ST_TRAIL;
                            seq_d.cnt   = trail_eff - ONE;
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    seq_d.state = ST_EXIT;
                    seq_d.cnt   = exit_eff - ONE;
                end
            end
            ST_EXIT: begin
                if (tick) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                end
            end
            default: seq_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, cnt: '0, last: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        line_st = LINE_STOP;
        hs_bit  = 1'b0;
        unique case (seq_q.state)
            ST_REQ:  line_st = LINE_REQ;
            ST_PREP: line_st = LINE_BRIDGE;
            ST_ZERO: line_st = LINE_HS;
            ST_SYNC, ST_DATA: begin
                line_st = LINE_HS;
                hs_bit  = cur_bit;
            end
            ST_TRAIL: begin
                line_st = LINE_HS;
                hs_bit  = ~last_bit;
            end
            default: line_st = LINE_STOP;
        endcase
    end

    // Checking support: cycles spent in the current state, saturating.
    logic [CNT_W:0] dwell_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dwell_q <= '0;
        end else if (seq_d.state != seq_q.state) begin
            dwell_q <= (CNT_W+1)'(1);
        end else if (dwell_q != '1) begin
            dwell_q <= dwell_q + (CNT_W+1)'(1);
        end
    end

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_REQ && $past(seq_q.state) == ST_IDLE)
        |-> ($past(start_req) && $past(clk_lane_rdy))); // R2

    AST_PREP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_ZERO && $past(seq_q.state) == ST_PREP)
        |-> ($past(dwell_q) >= (CNT_W+1)'(PREP_LO) && $past(dwell_q) <= (CNT_W+1)'(PREP_HI))); // R3

    AST_TRAIL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_TRAIL && $past(seq_q.state) == ST_TRAIL) |-> $stable(hs_bit)); // R5

    AST_TRAIL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_EXIT && $past(seq_q.state) == ST_TRAIL)
        |-> ($past(dwell_q) >= (CNT_W+1)'(TRAIL_LO) && $past(dwell_q) <= (CNT_W+1)'(TRAIL_HI))); // R6

    AST_EXIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_IDLE && $past(seq_q.state) == ST_EXIT)
        |-> ($past(dwell_q) >= (CNT_W+1)'(EXIT_LO))); // R7

    AST_READY_IN_HS: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (line_st == LINE_HS)); // R8

    AST_QUIET_OUTSIDE_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_st != LINE_HS) |-> !hs_bit); // R11
endmodule

// File: tb/lane_burst_seq_tb.sv
module lane_burst_seq_tb;
    localparam int UI    = 8000;
    localparam int P_LO  = (40000 + UI - 1) / UI + 4;
    localparam int P_HI  = 85000 / UI + 6;
    localparam int T_LOA = (60000 + UI - 1) / UI + 4;
    localparam int T_LO  = (T_LOA > 8) ? T_LOA : 8;
    localparam int T_HI  = 105000 / UI + 12;
    localparam int X_LO  = (100000 + UI - 1) / UI;
    localparam logic [7:0] SYNC = 8'hB8;

    logic       clk = 1'b0, rst_n = 1'b0, rdy = 1'b0, start = 1'b0;
    logic [7:0] c_lpx = 8'd1, c_prep = 8'd9, c_zero = 8'd1, c_trail = 8'd12, c_exit = 8'd13;
    logic [7:0] s_data = 8'd0;
    logic       s_valid = 1'b0, s_last = 1'b0;
    logic       s_ready;
    logic [1:0] line_st;
    logic       hs_bit;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [7:0] pay [0:3];
    int n_pay = 0, idx = 0;
    bit use_last = 1'b0;

    always #4 clk = ~clk;

    lane_burst_seq #(.UI_PS(UI)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_lane_rdy(rdy), .start_req(start),
        .cfg_lpx(c_lpx), .cfg_prep(c_prep), .cfg_zero(c_zero),
        .cfg_trail(c_trail), .cfg_exit(c_exit),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .line_st(line_st), .hs_bit(hs_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_stream();
        s_valid = (idx < n_pay);
        s_data  = (idx < n_pay) ? pay[idx] : 8'd0;
        s_last  = use_last && (idx == n_pay - 1);
    endtask

    // Called at a falling edge: checks this cycle, then moves to the next falling edge.
    task automatic step(input string req, input int code, input int bitv, input int rdy_exp);
        bit take;
        chk(req, int'(line_st), code);
        chk(req, int'(hs_bit), bitv);
        chk(req, int'(s_ready), rdy_exp);
        take = s_ready && s_valid;
        @(negedge clk);
        if (take) idx++;
        drive_stream();
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    task automatic reset_pulse();
        rst_n = 1'b0;
        start = 1'b0;
        @(negedge clk);
        chk("R1 in reset", int'(line_st), 0);
        chk("R1 in reset", int'(s_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", int'(line_st), 0);
        chk("R1 after reset", int'(hs_bit), 0);
        chk("R1 after reset", int'(s_ready), 0);
    endtask

    task automatic burst(input int lpx, input int prep, input int zero,
                         input int trail, input int ext);
        int le, pe, ze, te, xe;
        bit lastb;
        le = (lpx < 1) ? 1 : lpx;
        pe = clampi(prep, P_LO, P_HI);
        ze = (zero < 1) ? 1 : zero;
        te = clampi(trail, T_LO, T_HI);
        xe = (ext < X_LO) ? X_LO : ext;
        c_lpx = 8'(lpx); c_prep = 8'(prep); c_zero = 8'(zero);
        c_trail = 8'(trail); c_exit = 8'(ext);
        idx = 0;
        drive_stream();
        rdy   = 1'b1;
        start = 1'b1;
        @(negedge clk);
        for (int i = 0; i < le; i++) step("R2", 1, 0, 0);
        for (int i = 0; i < pe; i++) step("R3", 2, 0, 0);
        for (int i = 0; i < ze; i++) step("R4", 3, 0, 0);
        for (int k = 0; k < 8; k++) step("R4", 3, int'(SYNC[k]), (k == 7) ? 1 : 0);
        lastb = SYNC[7];
        for (int b = 0; b < n_pay; b++) begin
            for (int k = 0; k < 8; k++) begin
                step((use_last && b == n_pay - 1) ? "R9" : "R8", 3, int'(pay[b][k]),
                     (k == 7 && !(use_last && b == n_pay - 1)) ? 1 : 0);
            end
            lastb = pay[b][7];
        end
        for (int i = 0; i < te; i++)
            step(use_last && n_pay > 0 ? "R5 R6" : "R10 R5 R6", 3, int'(!lastb), 0);
        for (int i = 0; i < xe + 1; i++) step("R7 R11", 0, 0, 0);
        chk("R7 next request", int'(line_st), 1);
        reset_pulse();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        int lpx_set[2]   = '{0, 2};
        int prep_set[4]  = '{0, 9, 16, 30};
        int zero_set[2]  = '{0, 4};
        int trail_set[4] = '{0, 12, 25, 40};
        int exit_set[3]  = '{0, 13, 20};
        seed = 0;
        @(negedge clk);
        chk("R1 in reset", int'(line_st), 0);
        chk("R1 in reset", int'(hs_bit), 0);
        chk("R1 in reset", int'(s_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: a request without the clock lane ready is held off
        start = 1'b1;
        rdy   = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R2 clock lane not ready", int'(line_st), 0);
        end
        rdy = 1'b1;
        @(negedge clk);
        chk("R2 clock lane ready", int'(line_st), 1);
        reset_pulse();
        foreach (lpx_set[a])
        foreach (prep_set[b])
        foreach (zero_set[c])
        foreach (trail_set[d])
        foreach (exit_set[e])
        for (int m = 0; m < 4; m++) begin
            seed++;
            for (int j = 0; j < 4; j++) pay[j] = 8'(j * 73 + seed * 29 + 5);
            case (m)
                0: begin n_pay = 0; use_last = 1'b0; end
                1: begin n_pay = 1; use_last = 1'b1; end
                2: begin n_pay = 3; use_last = 1'b1; end
                default: begin n_pay = 2; use_last = 1'b0; end
            endcase
            burst(lpx_set[a], prep_set[b], zero_set[c], trail_set[d], exit_set[e]);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule